// File: doc/BRIEF.md
# Divider Setting Programming Port

This block takes divider settings for a frequency synthesizer from a microprocessor. The settings arrive as 4-bit words. A 3-bit select picks which of eight staging words is written, and a level-sensitive program strobe controls the write. The strobe is asynchronous to the system clock, so it is synchronised first. While the synchronised strobe is high, the selected staging word tracks the nibble input. When the strobe is low, the inputs are ignored.

The staged words are not visible at the outputs until word 1 (select code 0) is written. When the strobe falls with select code 0, the whole staged image is copied into the output registers in one clock edge. These registers hold the 11-bit reference ratio, the 10-bit main ratio and the 7-bit swallow ratio. On that same edge, a one-cycle load pulse tells the divider chain to reset and reload. Software therefore writes the other words in any order and writes word 1 last.

Top module: `synth_prog_port`

## Requirements
- R1: While reset is asserted, and after it, the staging words and the outputs take the values reference = 3, main = 8 and swallow = 0. The load pulse is low. After reset, committing word 1 with nibble 0 gives these same values.
- R2: While the strobe is low, changes on the select and nibble inputs do not alter any staged word, any output or the load pulse.
- R3: The main ratio maps as follows. Bits 9..6 come from word 3 (select 2), nibble bits 3..0. Bits 5..2 come from word 2 (select 1). Bits 1..0 come from word 1 (select 0), nibble bits 3..2. Nibble bits 1..0 of word 1 are ignored.
- R4: The swallow ratio maps as follows. Bits 3..0 come from word 4 (select 3). Bits 6..4 come from word 5 (select 4), nibble bits 2..0. Nibble bit 3 of word 5 is ignored.
- R5: The reference ratio maps as follows. Bits 3..0 come from word 6 (select 5). Bits 7..4 come from word 7 (select 6). Bits 10..8 come from word 8 (select 7), nibble bits 2..0. Nibble bit 3 of word 8 is ignored.
- R6: Writing any word other than word 1 leaves the outputs unchanged and raises no load pulse. Outputs change only in the cycle the load pulse is high.
- R7: When the strobe falls while select is 0, the outputs change and the load pulse rises on the (SYNC_STAGES+1)th rising clock edge after the fall. The load pulse stays high for exactly one cycle. Select and nibble must be held stable through that edge.
- R8: While the strobe is high, the addressed word follows the nibble input. The value present just before the strobe falls is the one retained.
- R9: Staged words are kept across commits and may be written in any order. A commit always uses the latest value of every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Program strobe, level sensitive, asynchronous |
| sel_i | input | 3 | Word select, code n addresses word n+1 |
| nib_i | input | 4 | Data nibble, bit 3 most significant |
| ref_div_o | output | 11 | Committed reference ratio |
| main_div_o | output | 10 | Committed main ratio |
| swal_div_o | output | 7 | Committed swallow ratio |
| load_o | output | 1 | One-cycle reload pulse to the divider chain |

## Verification
Every word is swept through all sixteen nibble values, and each value is committed through word 1. This separates a wrong bit position from a dropped or leaked unused bit, in each of the three output fields. A non-commit word is always written before its commit, which shows whether the outputs move early. Other patterns check further cases:
- Toggling select and nibble with the strobe low catches writes that should be ignored.
- Changing the nibble in the middle of a strobe catches a design that holds the first value instead of the last.
- A reverse-order fill followed by a repeated commit separates correct retention from accidental clearing.
- A second reset catches staging words that are not restored.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int NIB_W    = 4;
    localparam int WORD_CNT = 8;
    localparam int SEL_W    = $clog2(WORD_CNT);
    localparam int R_W      = 11;
    localparam int M_W      = 10;
    localparam int A_W      = 7;

    // word slots, index equals select code
    localparam int W_M_LO  = 0;
    localparam int W_M_MID = 1;
    localparam int W_M_HI  = 2;
    localparam int W_A_LO  = 3;
    localparam int W_A_HI  = 4;
    localparam int W_R_LO  = 5;
    localparam int W_R_MID = 6;
    localparam int W_R_HI  = 7;

    typedef logic [NIB_W-1:0]       nib_t;
    typedef nib_t [WORD_CNT-1:0]    image_t;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
    } div_set_t;

    localparam div_set_t DIV_RESET = '{r: 11'd3, m: 10'd8, a: 7'd0};

    function automatic image_t to_words(input div_set_t d);
        image_t img;
        img               = '0;
        img[W_M_LO][3:2]  = d.m[1:0];
        img[W_M_MID]      = d.m[5:2];
        img[W_M_HI]       = d.m[9:6];
        img[W_A_LO]       = d.a[3:0];
        img[W_A_HI][2:0]  = d.a[6:4];
        img[W_R_LO]       = d.r[3:0];
        img[W_R_MID]      = d.r[7:4];
        img[W_R_HI][2:0]  = d.r[10:8];
        return img;
    endfunction

endpackage

// File: rtl/prog_strobe_sync.sv
module prog_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_i,
    output logic level_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], strb_i};
        st_d.last = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.sh[STAGES-1];
    assign fall_o  = st_q.last & ~st_q.sh[STAGES-1];
endmodule

// File: rtl/prog_stage_bank.sv
module prog_stage_bank
    import synth_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  nib_t             nib_i,
    output image_t           img_o
);
    localparam image_t IMG_RESET = to_words(DIV_RESET);

    image_t img_d, img_q;

    for (genvar w = 0; w < WORD_CNT; w++) begin : g_word
        always_comb begin
            img_d[w] = img_q[w];
            if (wr_en_i && (sel_i == SEL_W'(w))) img_d[w] = nib_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) img_q <= IMG_RESET;
        else        img_q <= img_d;
    end

    assign img_o = img_q;
endmodule

// File: rtl/prog_field_pack.sv
module prog_field_pack
    import synth_prog_pkg::*;
(
    input  image_t   img_i,
    output div_set_t set_o
);
    logic unused_bits;

    always_comb begin
        set_o.m = {img_i[W_M_HI], img_i[W_M_MID], img_i[W_M_LO][3:2]};
        set_o.a = {img_i[W_A_HI][2:0], img_i[W_A_LO]};
        set_o.r = {img_i[W_R_HI][2:0], img_i[W_R_MID], img_i[W_R_LO]};
    end

    assign unused_bits = ^{img_i[W_M_LO][1:0], img_i[W_A_HI][3], img_i[W_R_HI][3]};
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic [R_W-1:0]   ref_div_o,
    output logic [M_W-1:0]   main_div_o,
    output logic [A_W-1:0]   swal_div_o,
    output logic             load_o
);
    localparam logic [SEL_W-1:0] COMMIT_SEL = SEL_W'(W_M_LO);

    typedef struct packed {
        div_set_t cur;
        logic     load;
    } port_st_t;

    logic     strb_lvl, strb_fall, commit;
    image_t   stage_img;
    div_set_t staged_set;
    port_st_t st_d, st_q;

    prog_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb_i  (strobe_i),
        .level_o (strb_lvl),
        .fall_o  (strb_fall)
    );

    prog_stage_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (strb_lvl),
        .sel_i   (sel_i),
        .nib_i   (nib_i),
        .img_o   (stage_img)
    );

    prog_field_pack u_pack (
        .img_i (stage_img),
        .set_o (staged_set)
    );

    assign commit = strb_fall && (sel_i == COMMIT_SEL);

    always_comb begin
        st_d      = st_q;
        st_d.load = commit;
        if (commit) st_d.cur = staged_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cur: DIV_RESET, load: 1'b0};
        else        st_q <= st_d;
    end

    assign ref_div_o  = st_q.cur.r;
    assign main_div_o = st_q.cur.m;
    assign swal_div_o = st_q.cur.a;
    assign load_o     = st_q.load;
endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  sel_i,
    input logic [10:0] ref_div_o,
    input logic [9:0]  main_div_o,
    input logic [6:0]  swal_div_o,
    input logic        load_o
);
    assert_reset_defaults_R1: assert property (@(posedge clk)
        !rst_n |=> (ref_div_o == 11'd3 && main_div_o == 10'd8 &&
                    swal_div_o == 7'd0 && !load_o));

    assert_single_cycle_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |-> ($stable(ref_div_o) && $stable(main_div_o) && $stable(swal_div_o)));

    assert_load_from_word1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ($past(sel_i) == 3'd0));
endmodule

bind synth_prog_port synth_prog_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .ref_div_o  (ref_div_o),
    .main_div_o (main_div_o),
    .swal_div_o (swal_div_o),
    .load_o     (load_o)
);

// File: tb/synth_prog_port_tb_top.sv
module synth_prog_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [3:0]  nib = 4'd0;
    logic [10:0] ref_o;
    logic [9:0]  main_o;
    logic [6:0]  swal_o;
    logic        load;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int img [8];
    int cur_r, cur_m, cur_a;

    always #2 clk = ~clk;

    synth_prog_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (strobe),
        .sel_i      (sel),
        .nib_i      (nib),
        .ref_div_o  (ref_o),
        .main_div_o (main_o),
        .swal_div_o (swal_o),
        .load_o     (load)
    );

    function automatic int exp_m();
        return img[2] * 64 + img[1] * 4 + img[0] / 4;
    endfunction
    function automatic int exp_a();
        return (img[4] % 8) * 16 + img[3];
    endfunction
    function automatic int exp_r();
        return (img[7] % 8) * 256 + img[6] * 16 + img[5];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) img[i] = 0;
        img[1] = 2;
        img[5] = 3;
        cur_r = 3; cur_m = 8; cur_a = 0;
    endtask

    task automatic check_out(input string tag, input bit exp_load);
        checks++;
        if (int'(ref_o) != cur_r || int'(main_o) != cur_m ||
            int'(swal_o) != cur_a || load != exp_load) begin
            fails++;
            $display("FAIL %s: got r=%0d m=%0d a=%0d load=%0b, expected r=%0d m=%0d a=%0d load=%0b",
                     tag, ref_o, main_o, swal_o, load, cur_r, cur_m, cur_a, exp_load);
        end
    endtask

    task automatic write_word(input int w, input int v, input string tag);
        @(negedge clk);
        sel = 3'(w); nib = 4'(v); strobe = 1'b1;
        repeat (3) @(negedge clk);
        strobe = 1'b0;
        img[w] = v;
        if (w == 0) begin
            @(negedge clk);
            @(negedge clk);
            check_out("R7 before edge", 1'b0);
            cur_r = exp_r(); cur_m = exp_m(); cur_a = exp_a();
            @(negedge clk);
            check_out(tag, 1'b1);
            @(negedge clk);
            check_out("R7 pulse end", 1'b0);
        end else begin
            repeat (4) begin
                @(negedge clk);
                check_out("R6", 1'b0);
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check_out("R1 in reset", 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_out("R1 after reset", 1'b0);
    endtask

    initial begin
        model_reset();
        do_reset();
        write_word(0, 0, "R1 commit defaults");

        // R3 R4 R5: every word through every nibble value
        for (int w = 0; w < 8; w++) begin
            for (int v = 0; v < 16; v++) begin
                string tag;
                tag = (w < 3) ? "R3" : ((w < 5) ? "R4" : "R5");
                if (w != 0) begin
                    write_word(w, v, tag);
                    write_word(0, img[0], tag);
                end else begin
                    write_word(0, v, tag);
                end
            end
        end

        // R2: inputs wiggle with strobe low
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            sel = 3'(k % 8); nib = 4'((k * 5 + 3) % 16);
            check_out("R2 strobe low", 1'b0);
        end
        write_word(0, img[0], "R2 staged unchanged");

        // R8: last value during strobe wins
        @(negedge clk);
        sel = 3'd3; nib = 4'd5; strobe = 1'b1;
        repeat (3) @(negedge clk);
        nib = 4'd9;
        repeat (3) @(negedge clk);
        strobe = 1'b0;
        img[3] = 9;
        repeat (4) @(negedge clk);
        write_word(0, 4'hC, "R8 follow");

        // R9: reverse order fill, then repeated commit
        for (int w = 7; w >= 1; w--) write_word(w, (w * 7 + 2) % 16, "R9 fill");
        write_word(0, 4'h6, "R9 commit");
        write_word(0, 4'h6, "R9 recommit");

        // R1: reset restores staging
        do_reset();
        write_word(0, 0, "R1 staging restored");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule